// File: doc/BRIEF.md
# Dual-Compare 8-Bit Timer Counter

An 8-bit counter advanced by a one-cycle timer tick enable, with two compare channels (A and B) watching it on every tick. Each tick whose count equals a channel's active compare value sets that channel's flag. A third flag marks the counter passing zero. Each flag drives an interrupt request through its own mask bit. The count ceiling (TOP) is either the all-ones value or channel A's active compare value, depending on the mode.

Compare values are written through a buffer. In the two immediate modes a write reaches the active value at once. In the buffered modes the buffer is copied at a fixed point of the count cycle, so the active value never changes mid-period. The counter itself can be loaded directly, and the tick after a load cannot produce a compare match. Every pin is a plain control or status signal. No stream or handshake interface exists, so nothing can be back-pressured. The tick source lives outside the block; holding `tick_en` low means no clock source is selected.

Top module: `tick_timer8`

## Requirements
- R1: After reset the count is 0x00, every flag and interrupt request is 0, both active compare values are 0x00, and the counting direction is up.
- R2: On a cycle with `tick_en` low and no count write, the count does not change.
- R3: In modes 0, 1 and 2 each tick adds one to the count. A tick taken at TOP loads 0x00 instead and sets the overflow flag (`flags[0]`). TOP is 0xFF in modes 0 and 2 and channel A's active compare value in mode 1.
- R4: In mode 3 the count rises to 0xFF, then falls to 0x00, then rises again. A tick at 0xFF while rising loads 0xFE. A tick at 0x00 while falling loads 0x01 and sets `flags[0]`.
- R5: A tick taken while the count equals a channel's active compare value sets that channel's flag at the same edge. Channel A uses `flags[1]` and channel B uses `flags[2]`.
- R6: A compare write (`cmp_wr_en[0]` for A, `cmp_wr_en[1]` for B) updates the active value immediately in modes 0 and 1. In mode 2 it is copied to the active value on a tick at TOP. In mode 3 it is copied on a tick at 0x00.
- R7: Writing a one to a `flag_clr` bit clears that flag. If a set event occurs in the same cycle, the flag is set.
- R8: `irq[k]` is high exactly when `flags[k]` and `mask[k]` are both high.
- R9: A count write loads `cnt_wr_data` at the next edge and takes priority over a tick in that cycle. The first tick after a count write produces no compare match.
- R10: `at_bottom` is high while the count is 0x00, `at_max` while it is 0xFF, and `at_top` while it equals the current TOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timer tick; low holds the counter |
| mode | input | 2 | 0 up/0xFF, 1 up/TOP=A, 2 up/0xFF buffered, 3 up-down buffered |
| cnt_wr_en | input | 1 | Load the counter |
| cnt_wr_data | input | 8 | Counter load value |
| cmp_wr_en | input | 2 | Compare write strobe, bit 0 channel A, bit 1 channel B |
| cmp_wr_data | input | 8 | Compare write value |
| flag_clr | input | 3 | Write-one-to-clear for flags |
| mask | input | 3 | Interrupt mask per flag |
| count | output | 8 | Counter value |
| flags | output | 3 | Bit 0 overflow, bit 1 match A, bit 2 match B |
| irq | output | 3 | Masked interrupt requests |
| at_bottom | output | 1 | Count is 0x00 |
| at_max | output | 1 | Count is 0xFF |
| at_top | output | 1 | Count equals current TOP |

## Verification
A wrong direction bit or a bad wrap decision shows on `count` one tick later. A wrong active compare value shows up only when the count passes the wrong value, so flag timing is checked on the exact tick the match must occur. A buffer copied at the wrong point stays hidden until the next pass of the compare value. Scenarios therefore sweep past the stale and the fresh value in each buffered mode. A stuck match-suppress bit is caught by a match expected on the second tick after a load.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  typedef enum logic [1:0] {
    TM_UP_FULL = 2'd0,
    TM_UP_CMPA = 2'd1,
    TM_UP_BUF  = 2'd2,
    TM_UPDOWN  = 2'd3
  } tmr_mode_e;
endpackage

// File: rtl/tmr8_counter.sv
module tmr8_counter
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  tmr_mode_e        mode,
  input  logic [CNT_W-1:0] top_val,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count_q,
  output logic             at_top,
  output logic             at_bot,
  output logic             ovf_evt,
  output logic             load_evt,
  output logic             match_ok
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic dir_down_q;
  logic block_q;
  logic adv;

  assign adv     = tick_en & ~wr_en;
  assign at_top  = (count_q == top_val);
  assign at_bot  = (count_q == ZERO);
  assign match_ok = adv & ~block_q;

  always_comb begin
    ovf_evt  = 1'b0;
    load_evt = 1'b0;
    if (adv) begin
      case (mode)
        TM_UPDOWN: begin
          ovf_evt  = dir_down_q & at_bot;
          load_evt = at_bot;
        end
        TM_UP_BUF: begin
          ovf_evt  = at_top;
          load_evt = at_top;
        end
        default: ovf_evt = at_top;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q    <= ZERO;
      dir_down_q <= 1'b0;
      block_q    <= 1'b0;
    end else begin
      if (wr_en) begin
        count_q <= wr_data;
        block_q <= 1'b1;
      end else if (tick_en) begin
        block_q <= 1'b0;
        if (mode == TM_UPDOWN) begin
          if (!dir_down_q) begin
            if (at_top) begin
              dir_down_q <= 1'b1;
              count_q    <= count_q - ONE;
            end else begin
              count_q <= count_q + ONE;
            end
          end else begin
            if (at_bot) begin
              dir_down_q <= 1'b0;
              count_q    <= count_q + ONE;
            end else begin
              count_q <= count_q - ONE;
            end
          end
        end else begin
          count_q <= at_top ? ZERO : count_q + ONE;
        end
      end
      if (mode != TM_UPDOWN) dir_down_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr8_cmp_chan.sv
module tmr8_cmp_chan
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_mode_e        mode,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             load_evt,
  input  logic [CNT_W-1:0] count,
  input  logic             match_ok,
  output logic [CNT_W-1:0] act_q,
  output logic             match_evt
);
  logic [CNT_W-1:0] buf_q;
  logic             direct;

  assign direct    = (mode == TM_UP_FULL) || (mode == TM_UP_CMPA);
  assign match_evt = match_ok && (count == act_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (wr_en) buf_q <= wr_data;
      if (direct && wr_en) act_q <= wr_data;
      else if (!direct && load_evt) act_q <= buf_q;
    end
  end
endmodule

// File: rtl/tmr8_flags.sv
module tmr8_flags #(
  parameter int N_FLG = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_FLG-1:0] set_evt,
  input  logic [N_FLG-1:0] clr,
  input  logic [N_FLG-1:0] mask,
  output logic [N_FLG-1:0] flags_q,
  output logic [N_FLG-1:0] irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= set_evt | (flags_q & ~clr);
  end

  for (genvar k = 0; k < N_FLG; k++) begin : g_irq
    assign irq[k] = flags_q[k] & mask[k];
  end
endmodule

// File: rtl/tick_timer8.sv
module tick_timer8
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int N_CMP = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic [1:0]         mode,
  input  logic               cnt_wr_en,
  input  logic [CNT_W-1:0]   cnt_wr_data,
  input  logic [N_CMP-1:0]   cmp_wr_en,
  input  logic [CNT_W-1:0]   cmp_wr_data,
  input  logic [N_CMP:0]     flag_clr,
  input  logic [N_CMP:0]     mask,
  output logic [CNT_W-1:0]   count,
  output logic [N_CMP:0]     flags,
  output logic [N_CMP:0]     irq,
  output logic               at_bottom,
  output logic               at_max,
  output logic               at_top
);
  localparam int N_FLG = N_CMP + 1;

  tmr_mode_e        mode_e;
  logic [CNT_W-1:0] top_val;
  logic [CNT_W-1:0] cmp_act [N_CMP];
  logic [N_CMP-1:0] match_evt;
  logic             ovf_evt, load_evt, match_ok;

  assign mode_e  = tmr_mode_e'(mode);
  assign top_val = (mode_e == TM_UP_CMPA) ? cmp_act[0] : {CNT_W{1'b1}};
  assign at_max  = (count == {CNT_W{1'b1}});

  tmr8_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .mode     (mode_e),
    .top_val  (top_val),
    .wr_en    (cnt_wr_en),
    .wr_data  (cnt_wr_data),
    .count_q  (count),
    .at_top   (at_top),
    .at_bot   (at_bottom),
    .ovf_evt  (ovf_evt),
    .load_evt (load_evt),
    .match_ok (match_ok)
  );

  for (genvar c = 0; c < N_CMP; c++) begin : g_cmp
    tmr8_cmp_chan #(.CNT_W(CNT_W)) chan_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode_e),
      .wr_en     (cmp_wr_en[c]),
      .wr_data   (cmp_wr_data),
      .load_evt  (load_evt),
      .count     (count),
      .match_ok  (match_ok),
      .act_q     (cmp_act[c]),
      .match_evt (match_evt[c])
    );
  end

  tmr8_flags #(.N_FLG(N_FLG)) flg_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt ({match_evt, ovf_evt}),
    .clr     (flag_clr),
    .mask    (mask),
    .flags_q (flags),
    .irq     (irq)
  );
endmodule

// File: rtl/tmr8_checker.sv
module tmr8_checker #(
  parameter int CNT_W = 8,
  parameter int N_CMP = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic [1:0]       mode,
  input logic             cnt_wr_en,
  input logic [CNT_W-1:0] cnt_wr_data,
  input logic [N_CMP:0]   flag_clr,
  input logic [N_CMP:0]   mask,
  input logic [CNT_W-1:0] count,
  input logic [N_CMP:0]   flags,
  input logic [N_CMP:0]   irq
);
  logic adv;
  assign adv = tick_en && !cnt_wr_en;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !cnt_wr_en) |=> $stable(count)); // R2

  AST_WRAP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && mode == 2'd0 && count == {CNT_W{1'b1}}) |=> (count == '0 && flags[0])); // R3

  AST_UD_TURN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && mode == 2'd3 && count == '0) |=> (count == {{(CNT_W-1){1'b0}}, 1'b1})); // R4

  AST_UD_TURN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && mode == 2'd3 && count == {CNT_W{1'b1}}) |=> (count == {{(CNT_W-1){1'b1}}, 1'b0})); // R4

  AST_FLAG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(flags) & ~flags) & ~$past(flag_clr)) == '0)); // R7

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~mask) == '0)); // R8

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_en |=> (count == $past(cnt_wr_data))); // R9
endmodule

bind tick_timer8 tmr8_checker #(.CNT_W(CNT_W), .N_CMP(N_CMP)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_en     (tick_en),
  .mode        (mode),
  .cnt_wr_en   (cnt_wr_en),
  .cnt_wr_data (cnt_wr_data),
  .flag_clr    (flag_clr),
  .mask        (mask),
  .count       (count),
  .flags       (flags),
  .irq         (irq)
);

// File: tb/tick_timer8_tb_top.sv
`timescale 1ns/1ps
module tick_timer8_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       cnt_wr_en = 1'b0;
  logic [7:0] cnt_wr_data = 8'h00;
  logic [1:0] cmp_wr_en = 2'b00;
  logic [7:0] cmp_wr_data = 8'h00;
  logic [2:0] flag_clr = 3'b000;
  logic [2:0] mask = 3'b111;
  logic [7:0] count;
  logic [2:0] flags, irq;
  logic       at_bottom, at_max, at_top;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  tick_timer8 dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode(mode),
    .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
    .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data),
    .flag_clr(flag_clr), .mask(mask), .count(count), .flags(flags),
    .irq(irq), .at_bottom(at_bottom), .at_max(at_max), .at_top(at_top)
  );

  localparam logic [2:0] C_TICK = 3'd0, C_WCNT = 3'd1, C_WA = 3'd2, C_WB = 3'd3, C_CLR = 3'd4;

  typedef struct packed {
    logic [2:0] cmd;
    logic [1:0] md;
    logic [7:0] arg;
    logic [7:0] e_cnt;
    logic [2:0] e_flg;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{C_WA,   2'd0, 8'd10,  8'h00, 3'b000},
    '{C_WB,   2'd0, 8'd20,  8'h00, 3'b000},
    '{C_TICK, 2'd0, 8'd10,  8'h0A, 3'b000},
    '{C_TICK, 2'd0, 8'd1,   8'h0B, 3'b010},
    '{C_TICK, 2'd0, 8'd9,   8'h14, 3'b010},
    '{C_TICK, 2'd0, 8'd1,   8'h15, 3'b110},
    '{C_WCNT, 2'd0, 8'hFE,  8'hFE, 3'b110},
    '{C_TICK, 2'd0, 8'd2,   8'h00, 3'b111},
    '{C_CLR,  2'd0, 8'h07,  8'h00, 3'b000},
    '{C_TICK, 2'd1, 8'd10,  8'h0A, 3'b000},
    '{C_TICK, 2'd1, 8'd1,   8'h00, 3'b011},
    '{C_CLR,  2'd1, 8'h07,  8'h00, 3'b000},
    '{C_WA,   2'd2, 8'd5,   8'h00, 3'b000},
    '{C_TICK, 2'd2, 8'd6,   8'h06, 3'b000},
    '{C_WCNT, 2'd2, 8'hFF,  8'hFF, 3'b000},
    '{C_TICK, 2'd2, 8'd1,   8'h00, 3'b001},
    '{C_TICK, 2'd2, 8'd6,   8'h06, 3'b011},
    '{C_CLR,  2'd2, 8'h07,  8'h06, 3'b000},
    '{C_WCNT, 2'd3, 8'hFE,  8'hFE, 3'b000},
    '{C_TICK, 2'd3, 8'd3,   8'hFD, 3'b000},
    '{C_WB,   2'd3, 8'd3,   8'hFD, 3'b000},
    '{C_WCNT, 2'd3, 8'h02,  8'h02, 3'b000},
    '{C_TICK, 2'd3, 8'd3,   8'h01, 3'b001},
    '{C_TICK, 2'd3, 8'd2,   8'h03, 3'b001},
    '{C_TICK, 2'd3, 8'd1,   8'h04, 3'b101}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
    end
    tick_en = 1'b0;
  endtask

  task automatic wr_cnt(input logic [7:0] d);
    cnt_wr_en = 1'b1; cnt_wr_data = d;
    @(negedge clk);
    cnt_wr_en = 1'b0;
  endtask

  task automatic wr_cmp(input logic [1:0] sel, input logic [7:0] d);
    cmp_wr_en = sel; cmp_wr_data = d;
    @(negedge clk);
    cmp_wr_en = 2'b00;
  endtask

  task automatic clr(input logic [2:0] m);
    flag_clr = m;
    @(negedge clk);
    flag_clr = 3'b000;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<20000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1 count", count, 8'h00);
    check("R1 flags", {5'd0, flags}, 8'h00);
    check("R1 irq", {5'd0, irq}, 8'h00);
    check("R10 bottom at reset", {7'd0, at_bottom}, 8'h01);

    // R3 R4 R5 R6 R9: vector walk
    for (int v = 0; v < NV; v++) begin
      mode = VEC[v].md;
      case (VEC[v].cmd)
        C_TICK:  ticks(int'(VEC[v].arg));
        C_WCNT:  wr_cnt(VEC[v].arg);
        C_WA:    wr_cmp(2'b01, VEC[v].arg);
        C_WB:    wr_cmp(2'b10, VEC[v].arg);
        default: clr(VEC[v].arg[2:0]);
      endcase
      check($sformatf("R3/R4/R5/R6 vec%0d count", v), count, VEC[v].e_cnt);
      check($sformatf("R3/R4/R5/R6 vec%0d flags", v), {5'd0, flags}, {5'd0, VEC[v].e_flg});
    end

    // R2: no tick, no movement
    mode = 2'd0;
    repeat (20) @(negedge clk);
    check("R2 hold", count, 8'h04);
    check("R2 flags held", {5'd0, flags}, 8'h05);

    // R8: masking (flags = 101)
    mask = 3'b001; #1;
    check("R8 mask 001", {5'd0, irq}, 8'h01);
    mask = 3'b110; #1;
    check("R8 mask 110", {5'd0, irq}, 8'h04);
    mask = 3'b000; #1;
    check("R8 mask 000", {5'd0, irq}, 8'h00);
    mask = 3'b111;
    @(negedge clk);

    // R7: clear
    clr(3'b101);
    check("R7 clear", {5'd0, flags}, 8'h00);

    // R9: load suppresses next match
    wr_cmp(2'b01, 8'h40);
    wr_cnt(8'h40);
    ticks(1);
    check("R9 blocked count", count, 8'h41);
    check("R9 blocked flag", {5'd0, flags}, 8'h00);

    // R7: set wins over same-cycle clear; R5 match after blocked tick
    wr_cnt(8'h3F);
    ticks(1);
    check("R5 pre", {5'd0, flags}, 8'h00);
    tick_en = 1'b1; flag_clr = 3'b010;
    @(negedge clk);
    tick_en = 1'b0; flag_clr = 3'b000;
    check("R7 set wins", {5'd0, flags}, 8'h02);
    check("R5 count", count, 8'h41);
    clr(3'b010);

    // R9: write beats tick
    tick_en = 1'b1; cnt_wr_en = 1'b1; cnt_wr_data = 8'h77;
    @(negedge clk);
    tick_en = 1'b0; cnt_wr_en = 1'b0;
    check("R9 write over tick", count, 8'h77);

    // R10: status outputs
    mode = 2'd1;
    wr_cnt(8'h40);
    check("R10 top in mode1", {5'd0, at_top, at_max, at_bottom}, 8'h04);
    mode = 2'd0; #1;
    check("R10 not top in mode0", {7'd0, at_top}, 8'h00);
    wr_cnt(8'hFF);
    check("R10 max", {5'd0, at_top, at_max, at_bottom}, 8'h06);
    wr_cnt(8'h00);
    check("R10 bottom", {5'd0, at_top, at_max, at_bottom}, 8'h01);

    finish_run();
  end
endmodule